// File: doc/BRIEF.md
# DMA Channel Control and Status Register Unit

This block is the per-channel register front end of a descriptor-driven DMA engine. Software never writes the channel state directly. It writes a control word whose upper half is a bit mask and whose lower half holds the new values. The unit changes only the bits the mask selects and then works out the hardware state from the result: running, paused, woken, flushing, dead, active and branch-taken. The unit also holds the descriptor pointer and three condition-select words (interrupt, branch and wait), which the descriptor sequencer reads.

The unit has three outputs towards other logic. Towards the attached device it issues flush requests. Towards the sequencer it issues a one-cycle kick, so that an active channel resumes fetching descriptors, and a fetch pulse when a new descriptor pointer is accepted. The sequencer reports back through single-cycle strobes. These strobes kill the channel, stop it, record a branch and acknowledge a wake. All outputs are registered. A read returns data one cycle after the address is presented, and the unit uses a synchronous active-high reset.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, every register reads zero and `kick_o`, `flush_req_o` and `fetch_o` are low.
- R2: Status bit positions are as follows: run 15, pause 14, flush 13, wake 12, dead 11, active 10, branch-taken 8. A control word takes its mask from bits 31:16 and its values from bits 15:0. A control write with mask bit 15 and value bit 15 both at 1 sets run. When pause is clear, that write also sets active.
- R3: A control write with mask bit 15 at 1 and value bit 15 at 0 clears run, dead and active, and it raises `flush_req_o` for one cycle.
- R4: A control write changes no status bit that its mask leaves at 0.
- R5: A control write that sets wake takes effect only when run is set after the write. On a running, unpaused channel it sets wake and active.
- R6: A masked pause write copies the value bit into pause. If pause is set or run is clear after any control write, active is cleared and `flush_req_o` pulses. Otherwise, active is set when the write touched run or pause.
- R7: A control write with mask and value bit 13 at 1 raises `flush_req_o` for one cycle. The flush status bit is visible in that same cycle only and drops on the next edge.
- R8: A read of word index 0 (control) returns the status word. Word index 1 also returns the status word, and writes to index 1 are ignored.
- R9: A write to the descriptor pointer (index 2) is ignored while active is set. An accepted write stores the value with bits 3:0 cleared and raises `fetch_o` for one cycle.
- R10: Each sequencer strobe acts on the next edge: `seq_set_dead` sets dead, `seq_clr_active` clears active, `seq_set_bt` and `seq_clr_bt` set and clear branch-taken, and `seq_clr_wake` clears wake.
- R11: When a control write and a sequencer strobe arrive in the same cycle, the software write decides run, pause and active, and `seq_set_dead` decides dead.
- R12: Every control write that leaves active set is followed by a one-cycle `kick_o` pulse. `kick_o` never rises at any other time.
- R13: The interrupt, branch and wait select words (indices 3, 4 and 5) hold the full written word. Unmapped indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address within the channel window (word aligned) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| seq_set_dead | input | 1 | Sequencer: mark channel dead |
| seq_clr_active | input | 1 | Sequencer: channel stopped |
| seq_set_bt | input | 1 | Sequencer: branch taken |
| seq_clr_bt | input | 1 | Sequencer: sequential step, clear branch-taken |
| seq_clr_wake | input | 1 | Sequencer: descriptor fetched, clear wake |
| status_o | output | DATA_W | Status word |
| cmd_ptr_o | output | DATA_W | Descriptor pointer |
| fetch_o | output | 1 | One-cycle pulse after an accepted pointer write |
| intr_sel_o | output | DATA_W | Interrupt condition select word |
| br_sel_o | output | DATA_W | Branch condition select word |
| wait_sel_o | output | DATA_W | Wait condition select word |
| flush_req_o | output | 1 | One-cycle flush request to the device |
| kick_o | output | 1 | One-cycle resume pulse to the sequencer |

## Verification
The hardest case to reach from the ports is a software control write and a sequencer strobe landing in the same clock edge. This case needs exact cycle alignment of two otherwise independent agents. The bench has a dedicated task that asserts the bus write and the strobe at the same falling edge. It pairs a run-clear with a dead-set, and a run-set with an active-clear, and then checks the resulting status bits. The bench also reaches the brief one-cycle visibility of the flush bit by sampling status immediately after the write edge and once more one cycle later.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BT     = 8;

  localparam int NUM_SEL  = 3;

  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_STAT = 3'd1,
    IDX_CPTR = 3'd2,
    IDX_ISEL = 3'd3,
    IDX_BSEL = 3'd4,
    IDX_WSEL = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              seq_set_dead,
  input  logic              seq_clr_active,
  input  logic              seq_set_bt,
  input  logic              seq_clr_bt,
  input  logic              seq_clr_wake,
  output logic [DATA_W-1:0] status_o,
  output logic              flush_req_o,
  output logic              kick_o
);
  localparam int HALF = DATA_W / 2;

  logic run_q, pause_q, wake_q, dead_q, active_q, bt_q, flush_q;
  logic flush_req_q, kick_q;
  logic run_d, pause_d, wake_d, dead_d, active_d, bt_d, flush_d;
  logic do_flush, kick_d;
  logic [HALF-1:0] msk, val;

  assign msk = ctrl_wdata[DATA_W-1:HALF];
  assign val = ctrl_wdata[HALF-1:0];

  always_comb begin
    run_d    = run_q;
    pause_d  = pause_q;
    wake_d   = wake_q;
    dead_d   = dead_q;
    active_d = active_q;
    bt_d     = bt_q;
    flush_d  = 1'b0;
    do_flush = 1'b0;
    kick_d   = 1'b0;
    // sequencer strobes first; software may override run/pause/active/wake
    if (seq_clr_active) active_d = 1'b0;
    if (seq_set_bt)      bt_d = 1'b1;
    else if (seq_clr_bt) bt_d = 1'b0;
    if (seq_clr_wake)    wake_d = 1'b0;
    if (ctrl_we) begin
      if (msk[B_RUN]) begin
        if (val[B_RUN]) run_d = 1'b1;
        else begin
          run_d  = 1'b0;
          dead_d = 1'b0;
        end
      end
      if (msk[B_WAKE] && val[B_WAKE] && run_d) wake_d = 1'b1;
      if (msk[B_PAUSE]) pause_d = val[B_PAUSE];
      if (msk[B_FLUSH] && val[B_FLUSH]) begin
        flush_d  = 1'b1;
        do_flush = 1'b1;
      end
      if (pause_d || !run_d) begin
        active_d = 1'b0;
        do_flush = 1'b1;
      end else if (msk[B_RUN] || msk[B_PAUSE]) begin
        active_d = 1'b1;
      end else if (msk[B_WAKE] && val[B_WAKE]) begin
        active_d = 1'b1;
      end
      kick_d = active_d;
    end
    // the sequencer owns dead when both act in one cycle (R11)
    if (seq_set_dead) dead_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; pause_q <= 1'b0; wake_q <= 1'b0; dead_q <= 1'b0;
      active_q <= 1'b0; bt_q <= 1'b0; flush_q <= 1'b0;
      flush_req_q <= 1'b0; kick_q <= 1'b0;
    end else begin
      run_q <= run_d; pause_q <= pause_d; wake_q <= wake_d; dead_q <= dead_d;
      active_q <= active_d; bt_q <= bt_d; flush_q <= flush_d;
      flush_req_q <= do_flush; kick_q <= kick_d;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[B_RUN]    = run_q;
    status_o[B_PAUSE]  = pause_q;
    status_o[B_FLUSH]  = flush_q;
    status_o[B_WAKE]   = wake_q;
    status_o[B_DEAD]   = dead_q;
    status_o[B_ACTIVE] = active_q;
    status_o[B_BT]     = bt_q;
  end

  assign flush_req_o = flush_req_q;
  assign kick_o      = kick_q;
endmodule

// File: rtl/dcr_cptr.sv
module dcr_cptr #(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cptr_o,
  output logic              fetch_o
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cptr_o  <= '0;
      fetch_o <= 1'b0;
    end else begin
      fetch_o <= 1'b0;
      if (we && !locked) begin
        cptr_o  <= wdata & ALIGN_MASK;
        fetch_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
  import dcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DATA_W-1:0]         status,
  input  logic [DATA_W-1:0]         cptr,
  input  logic [NUM_SEL*DATA_W-1:0] sel_flat,
  output logic [DATA_W-1:0]         rdata_o
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (idx == IDX_W'(IDX_CTRL) || idx == IDX_W'(IDX_STAT)) rd_d = status;
    else if (idx == IDX_W'(IDX_CPTR)) rd_d = cptr;
    for (int i = 0; i < NUM_SEL; i++)
      if (idx == IDX_W'(int'(IDX_ISEL) + i)) rd_d = sel_flat[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dcr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              seq_set_dead,
  input  logic              seq_clr_active,
  input  logic              seq_set_bt,
  input  logic              seq_clr_bt,
  input  logic              seq_clr_wake,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] cmd_ptr_o,
  output logic              fetch_o,
  output logic [DATA_W-1:0] intr_sel_o,
  output logic [DATA_W-1:0] br_sel_o,
  output logic [DATA_W-1:0] wait_sel_o,
  output logic              flush_req_o,
  output logic              kick_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]          idx;
  logic [NUM_SEL*DATA_W-1:0] sel_flat;

  assign idx = bus_addr[ADDR_W-1:2];

  dcr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .ctrl_we(bus_we && idx == IDX_W'(IDX_CTRL)),
    .ctrl_wdata(bus_wdata),
    .seq_set_dead(seq_set_dead), .seq_clr_active(seq_clr_active),
    .seq_set_bt(seq_set_bt), .seq_clr_bt(seq_clr_bt), .seq_clr_wake(seq_clr_wake),
    .status_o(status_o), .flush_req_o(flush_req_o), .kick_o(kick_o)
  );

  dcr_cptr #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) cptr_i (
    .clk(clk), .rst(rst),
    .we(bus_we && idx == IDX_W'(IDX_CPTR)),
    .locked(status_o[B_ACTIVE]),
    .wdata(bus_wdata),
    .cptr_o(cmd_ptr_o), .fetch_o(fetch_o)
  );

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    logic [DATA_W-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (rst) sel_q <= '0;
      else if (bus_we && idx == IDX_W'(int'(IDX_ISEL) + g)) sel_q <= bus_wdata;
    end
    assign sel_flat[g*DATA_W +: DATA_W] = sel_q;
  end

  assign intr_sel_o = sel_flat[0*DATA_W +: DATA_W];
  assign br_sel_o   = sel_flat[1*DATA_W +: DATA_W];
  assign wait_sel_o = sel_flat[2*DATA_W +: DATA_W];

  dcr_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) rd_i (
    .clk(clk), .rst(rst), .idx(idx), .status(status_o),
    .cptr(cmd_ptr_o), .sel_flat(sel_flat), .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
  import dcr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int ALIGN_BITS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              seq_set_dead,
  input logic              seq_clr_wake,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] cmd_ptr_o,
  input logic              fetch_o,
  input logic              flush_req_o,
  input logic              kick_o
);
  localparam int HALF  = DATA_W / 2;
  localparam int IDX_W = ADDR_W - 2;

  logic ctrl_wr, cptr_wr;
  assign ctrl_wr = bus_we && bus_addr[ADDR_W-1:2] == IDX_W'(IDX_CTRL);
  assign cptr_wr = bus_we && bus_addr[ADDR_W-1:2] == IDX_W'(IDX_CPTR);

  p_stop_inactive_r3: assert property (@(posedge clk) disable iff (rst)
    !status_o[B_RUN] |-> !status_o[B_ACTIVE]);

  p_pause_inactive_r6: assert property (@(posedge clk) disable iff (rst)
    status_o[B_PAUSE] |-> !status_o[B_ACTIVE]);

  p_flush_visible_r7: assert property (@(posedge clk) disable iff (rst)
    status_o[B_FLUSH] |-> flush_req_o);

  p_cptr_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (cptr_wr && status_o[B_ACTIVE]) |=> ($stable(cmd_ptr_o) && !fetch_o));

  p_cptr_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    fetch_o |-> cmd_ptr_o[ALIGN_BITS-1:0] == '0);

  p_dead_wins_r11: assert property (@(posedge clk) disable iff (rst)
    seq_set_dead |=> status_o[B_DEAD]);

  p_kick_active_r12: assert property (@(posedge clk) disable iff (rst)
    kick_o |-> status_o[B_ACTIVE]);

  p_kick_needs_write_r12: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> !kick_o);

  p_wake_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !status_o[B_RUN] && !bus_wdata[HALF + B_RUN] && !seq_clr_wake)
      |=> status_o[B_WAKE] == $past(status_o[B_WAKE]));
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .seq_set_dead(seq_set_dead), .seq_clr_wake(seq_clr_wake), .status_o(status_o),
  .cmd_ptr_o(cmd_ptr_o), .fetch_o(fetch_o), .flush_req_o(flush_req_o), .kick_o(kick_o)
);

// File: tb/dma_chan_csr_tb_top.sv
module dma_chan_csr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic s_dead = 0, s_clr_act = 0, s_set_bt = 0, s_clr_bt = 0, s_clr_wake = 0;
  logic [DW-1:0] status_o, cmd_ptr_o, intr_sel_o, br_sel_o, wait_sel_o;
  logic fetch_o, flush_req_o, kick_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_csr #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .seq_set_dead(s_dead), .seq_clr_active(s_clr_act),
    .seq_set_bt(s_set_bt), .seq_clr_bt(s_clr_bt), .seq_clr_wake(s_clr_wake),
    .status_o(status_o), .cmd_ptr_o(cmd_ptr_o), .fetch_o(fetch_o),
    .intr_sel_o(intr_sel_o), .br_sel_o(br_sel_o), .wait_sel_o(wait_sel_o),
    .flush_req_o(flush_req_o), .kick_o(kick_o)
  );

  localparam logic [AW-1:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_CPTR = 5'h08,
                            A_ISEL = 5'h0C, A_BSEL = 5'h10, A_WSEL = 5'h14, A_NONE = 5'h1C;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic strobe(int which);
    @(negedge clk);
    case (which)
      0: s_dead = 1; 1: s_clr_act = 1; 2: s_set_bt = 1; 3: s_clr_bt = 1; default: s_clr_wake = 1;
    endcase
    @(negedge clk);
    {s_dead, s_clr_act, s_set_bt, s_clr_bt, s_clr_wake} = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_CPTR, d); chk("R1 cptr", d, 0);
    rd(A_WSEL, d); chk("R1 wsel", d, 0);
    chk("R1 pulses", {kick_o, flush_req_o, fetch_o}, 0);
  endtask

  task automatic t_cptr_idle();
    logic [DW-1:0] d;
    wr(A_CPTR, 32'h1234_567F);
    chk("R9 fetch", fetch_o, 1);
    rd(A_CPTR, d); chk("R9 align", d, 32'h1234_5670);
  endtask

  task automatic t_run();
    logic [DW-1:0] d;
    wr(A_CTRL, 32'h8000_8000);
    chk("R2 status", status_o, 32'h8400);
    chk("R12 kick", kick_o, 1);
    chk("R2 noflush", flush_req_o, 0);
    @(negedge clk); chk("R12 kick one cycle", kick_o, 0);
    rd(A_CTRL, d); chk("R8 ctrl reads status", d, 32'h8400);
    wr(A_CPTR, 32'hAAAA_0000);
    chk("R9 no fetch locked", fetch_o, 0);
    rd(A_CPTR, d); chk("R9 locked", d, 32'h1234_5670);
  endtask

  task automatic t_mask();
    wr(A_CTRL, 32'h0000_3FFF);
    chk("R4 unmasked unchanged", status_o, 32'h8400);
  endtask

  task automatic t_wake();
    wr(A_CTRL, 32'h1000_1000);
    chk("R5 wake running", status_o, 32'h9400);
    chk("R12 kick wake", kick_o, 1);
    strobe(4); chk("R10 clr wake", status_o, 32'h8400);
  endtask

  task automatic t_pause();
    wr(A_CTRL, 32'h4000_4000);
    chk("R6 paused", status_o, 32'hC000);
    chk("R6 flush on pause", flush_req_o, 1);
    chk("R12 no kick paused", kick_o, 0);
    wr(A_CTRL, 32'h4000_0000);
    chk("R6 resume", status_o, 32'h8400);
    chk("R6 kick resume", kick_o, 1);
  endtask

  task automatic t_flush();
    wr(A_CTRL, 32'h2000_2000);
    chk("R7 flush req", flush_req_o, 1);
    chk("R7 flush visible", status_o, 32'hA400);
    @(negedge clk);
    chk("R7 flush dropped", status_o, 32'h8400);
    chk("R7 req one cycle", flush_req_o, 0);
  endtask

  task automatic t_seq();
    strobe(2); chk("R10 set bt", status_o, 32'h8500);
    strobe(3); chk("R10 clr bt", status_o, 32'h8400);
    @(negedge clk); s_dead = 1; s_clr_act = 1;
    @(negedge clk); s_dead = 0; s_clr_act = 0;
    chk("R10 kill", status_o, 32'h8800);
  endtask

  task automatic t_stop();
    wr(A_CTRL, 32'h8000_0000);
    chk("R3 stopped", status_o, 32'h0000);
    chk("R3 flush", flush_req_o, 1);
    wr(A_CTRL, 32'h1000_1000);
    chk("R5 wake ignored", status_o, 32'h0000);
    chk("R6 flush while stopped", flush_req_o, 1);
    chk("R12 no kick stopped", kick_o, 0);
  endtask

  task automatic t_prio();
    wr(A_CTRL, 32'h8000_8000);
    @(negedge clk);
    bus_we = 1; bus_addr = A_CTRL; bus_wdata = 32'h8000_0000; s_dead = 1;
    @(negedge clk);
    bus_we = 0; s_dead = 0;
    chk("R11 dead beats clear", status_o, 32'h0800);
    bus_we = 1; bus_wdata = 32'h8000_8000; s_clr_act = 1;
    @(negedge clk);
    bus_we = 0; s_clr_act = 0;
    chk("R11 run beats stop", status_o, 32'h8C00);
    chk("R12 kick prio", kick_o, 1);
  endtask

  task automatic t_sel();
    logic [DW-1:0] d;
    wr(A_ISEL, 32'h000F_0005);
    wr(A_BSEL, 32'hDEAD_BEEF);
    wr(A_WSEL, 32'h0003_0001);
    rd(A_ISEL, d); chk("R13 isel", d, 32'h000F_0005);
    rd(A_BSEL, d); chk("R13 bsel", d, 32'hDEAD_BEEF);
    chk("R13 wsel port", wait_sel_o, 32'h0003_0001);
    rd(A_NONE, d); chk("R13 unmapped", d, 0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R8 status write ignored", d, 32'h8C00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_cptr_idle(); t_run(); t_mask(); t_wake(); t_pause();
    t_flush(); t_seq(); t_stop(); t_prio(); t_sel();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule